// File: doc/BRIEF.md
# Scaler Phase Parameter Calculator

This block turns the geometry of one image plane into the programming values a polyphase scaler needs. Software, or a sequencer upstream, presents a plane-selection bitmask, the source width and height in unsigned 16.16 fixed point, the destination width and height as integers and a rotation flag, then pulses `start`. The block latches the inputs and works out the horizontal and vertical upscale factors. It also produces the scaler input size and the output size, and the initial and per-pixel phase steps for each axis at sixteen sub-phase resolution. An enhancer enable is raised when a strong upscale is requested.

All six divisions run one after another through a single shared restoring divider, which produces one quotient bit per cycle. An empty mask means nothing is to be scaled: the block finishes at once with scaling disabled. A mask that names more than one plane is rejected, because only one plane can be scaled at a time. Geometry that would divide by zero is also rejected. Each run ends with a one-cycle `done` pulse, and the results stay on the outputs until the next accepted start.

Top module: `scaler_phase_calc`

## Requirements
- R1: A start with an all-zero `plane_mask` completes with `done` in the next cycle, with `scale_en`=0 and `err`=0, and with every numeric output cleared to 0. No division is performed.
- R2: A start with more than one bit set in `plane_mask` completes with `done` in the next cycle, with `err`=1, `scale_en`=0 and every numeric output 0. Bit i of the mask names plane i.
- R3: With exactly one mask bit set, `h_factor` is the low 32 bits of (`dst_w` << 32) / `src_w`, and `v_factor` is the same function of `dst_h` and `src_h`. Both are U16.16 values.
- R4: `enh_en` is 1 exactly when a run has completed with `scale_en`=1 and the integer part (bits 31:16) of `h_factor` or of `v_factor` is 2 or more.
- R5: With `rotated`=0, `in_w` is `src_w`[31:16] and `in_h` is `src_h`[31:16]. With `rotated`=1 (a 90 or 270 degree turn), `in_w` is `src_h`[31:16] and `in_h` is `src_w`[31:16].
- R6: `h_init` = ((`in_w` << 4) / `out_w` + 1) / 2, and `v_init` is the same function of `in_h` and `out_h`. Both use integer division.
- R7: `h_delta` = (`in_w` << 16) / `out_w`, and `v_delta` is the same function of `in_h` and `out_h`.
- R8: After a successful run, `out_w` and `out_h` equal `dst_w` and `dst_h`, `scale_en` is 1 and `err` is 0. `err` and `scale_en` are never 1 together.
- R9: With exactly one mask bit set, a zero `src_w`, `src_h`, `dst_w` or `dst_h` completes with `done` in the next cycle, with `err`=1, `scale_en`=0 and every numeric output 0.
- R10: Each accepted start produces exactly one `done` pulse, one cycle long. A `start` that arrives while a run is in progress is ignored. The outputs hold their values after `done` until the next accepted start.
- R11: After reset, `done`, `err`, `scale_en`, `enh_en` and every numeric output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; accepted only when idle |
| plane_mask | input | PLANES | One bit per plane to be scaled |
| src_w | input | 32 | Source width, U16.16 |
| src_h | input | 32 | Source height, U16.16 |
| dst_w | input | 16 | Destination width, integer |
| dst_h | input | 16 | Destination height, integer |
| rotated | input | 1 | 1 for a 90 or 270 degree rotation |
| h_factor | output | 32 | Horizontal upscale factor, U16.16 |
| v_factor | output | 32 | Vertical upscale factor, U16.16 |
| h_init | output | 20 | Horizontal initial phase |
| v_init | output | 20 | Vertical initial phase |
| h_delta | output | 32 | Horizontal phase step |
| v_delta | output | 32 | Vertical phase step |
| in_w | output | 16 | Scaler input width |
| in_h | output | 16 | Scaler input height |
| out_w | output | 16 | Scaler output width |
| out_h | output | 16 | Scaler output height |
| enh_en | output | 1 | Enhancer enable |
| scale_en | output | 1 | Scaling enabled by the last run |
| err | output | 1 | Last run was rejected |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench drives a 2x integer upscale, a non-integer downscale, a rotated plane whose axes differ, and a fractional source width. Together these separate the correct factor and phase arithmetic from swapped axes, from a dropped fraction and from wrong rounding of the initial phase. Two cases sit on either side of the enhancer threshold: a factor of 1.5 and a factor of exactly 2.0. A case with a tiny source and the widest destination shows that the factor keeps only its low 32 bits and that a zero input size gives zero phases. The early exits are covered by an empty mask, a two-plane mask and zero sizes on both the source and the destination side, and a second start issued during a run must leave the first result and its single done pulse untouched.

// File: rtl/scaler_phase_calc.sv
module scaler_phase_calc #(
  parameter int PLANES = 8,
  parameter int SZ_W   = 16,
  parameter int FR_W   = 16,
  parameter int PH_SH  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [PLANES-1:0]       plane_mask,
  input  logic [SZ_W+FR_W-1:0]    src_w,
  input  logic [SZ_W+FR_W-1:0]    src_h,
  input  logic [SZ_W-1:0]         dst_w,
  input  logic [SZ_W-1:0]         dst_h,
  input  logic                    rotated,
  output logic [SZ_W+FR_W-1:0]    h_factor,
  output logic [SZ_W+FR_W-1:0]    v_factor,
  output logic [SZ_W+PH_SH-1:0]   h_init,
  output logic [SZ_W+PH_SH-1:0]   v_init,
  output logic [SZ_W+FR_W-1:0]    h_delta,
  output logic [SZ_W+FR_W-1:0]    v_delta,
  output logic [SZ_W-1:0]         in_w,
  output logic [SZ_W-1:0]         in_h,
  output logic [SZ_W-1:0]         out_w,
  output logic [SZ_W-1:0]         out_h,
  output logic                    enh_en,
  output logic                    scale_en,
  output logic                    err,
  output logic                    done
);
  localparam int SRC_W  = SZ_W + FR_W;
  localparam int NUM_W  = SZ_W + 2 * FR_W;
  localparam int INIT_W = SZ_W + PH_SH;
  localparam int CNT_W  = $clog2(NUM_W);
  localparam logic [2:0] LAST_OP = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN, S_STORE} st_t;

  st_t              st;
  logic [2:0]       op;
  logic [CNT_W-1:0] cnt;
  logic [NUM_W-1:0] qn;
  logic [SRC_W-1:0] rem;
  logic [SRC_W-1:0] src_w_r, src_h_r;

  logic [NUM_W-1:0] num_sel;
  logic [SRC_W-1:0] den_sel;
  logic [SRC_W:0]   trial, diff;
  logic             ge;
  logic [INIT_W-1:0] rnd;

  wire multi    = |(plane_mask & (plane_mask - PLANES'(1)));
  wire zero_dim = (src_w == '0) | (src_h == '0) | (dst_w == '0) | (dst_h == '0);
  wire reject   = (plane_mask == '0) | multi | zero_dim;

  always_comb begin
    num_sel = '0;
    den_sel = '0;
    case (op)
      3'd0: begin num_sel = NUM_W'(out_w) << (2 * FR_W); den_sel = src_w_r; end
      3'd1: begin num_sel = NUM_W'(out_h) << (2 * FR_W); den_sel = src_h_r; end
      3'd2: begin num_sel = NUM_W'(in_w) << PH_SH;       den_sel = SRC_W'(out_w); end
      3'd3: begin num_sel = NUM_W'(in_w) << FR_W;        den_sel = SRC_W'(out_w); end
      3'd4: begin num_sel = NUM_W'(in_h) << PH_SH;       den_sel = SRC_W'(out_h); end
      3'd5: begin num_sel = NUM_W'(in_h) << FR_W;        den_sel = SRC_W'(out_h); end
      default: ;
    endcase
  end

  assign trial = {rem, qn[NUM_W-1]};
  assign diff  = trial - {1'b0, den_sel};
  assign ge    = trial >= {1'b0, den_sel};
  assign rnd   = {1'b0, qn[INIT_W-1:1]} + {{(INIT_W-1){1'b0}}, qn[0]};

  assign enh_en = scale_en & ((|h_factor[SRC_W-1:FR_W+1]) | (|v_factor[SRC_W-1:FR_W+1]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= '0; cnt <= '0; qn <= '0; rem <= '0;
      src_w_r <= '0; src_h_r <= '0;
      h_factor <= '0; v_factor <= '0; h_init <= '0; v_init <= '0;
      h_delta <= '0; v_delta <= '0; in_w <= '0; in_h <= '0;
      out_w <= '0; out_h <= '0; scale_en <= 1'b0; err <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          scale_en <= 1'b0;
          if (reject) begin
            h_factor <= '0; v_factor <= '0; h_init <= '0; v_init <= '0;
            h_delta <= '0; v_delta <= '0; in_w <= '0; in_h <= '0;
            out_w <= '0; out_h <= '0;
            err  <= (plane_mask != '0);
            done <= 1'b1;
          end else begin
            err     <= 1'b0;
            src_w_r <= src_w;
            src_h_r <= src_h;
            out_w   <= dst_w;
            out_h   <= dst_h;
            in_w    <= rotated ? src_h[SRC_W-1:FR_W] : src_w[SRC_W-1:FR_W];
            in_h    <= rotated ? src_w[SRC_W-1:FR_W] : src_h[SRC_W-1:FR_W];
            op      <= '0;
            st      <= S_LOAD;
          end
        end
        S_LOAD: begin
          qn  <= num_sel;
          rem <= '0;
          cnt <= '0;
          st  <= S_RUN;
        end
        S_RUN: begin
          qn  <= {qn[NUM_W-2:0], ge};
          rem <= ge ? diff[SRC_W-1:0] : trial[SRC_W-1:0];
          cnt <= cnt + CNT_W'(1);
          if (cnt == CNT_W'(NUM_W - 1)) st <= S_STORE;
        end
        S_STORE: begin
          case (op)
            3'd0: h_factor <= qn[SRC_W-1:0];
            3'd1: v_factor <= qn[SRC_W-1:0];
            3'd2: h_init   <= rnd;
            3'd3: h_delta  <= qn[SRC_W-1:0];
            3'd4: v_init   <= rnd;
            default: v_delta <= qn[SRC_W-1:0];
          endcase
          if (op == LAST_OP) begin
            scale_en <= 1'b1;
            done     <= 1'b1;
            st       <= S_IDLE;
          end else begin
            op <= op + 3'd1;
            st <= S_LOAD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_empty_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && plane_mask == '0) |=> (done && !err && !scale_en && h_factor == '0));

  assert_multi_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && multi) |=> (done && err && !scale_en));

  assert_rem_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN) |-> (rem < den_sel));

  assert_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !scale_en);

  assert_zero_div_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && plane_mask != '0 && !multi && zero_dim) |=> (done && err));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !start) |=> ($stable(h_factor) && $stable(v_delta) && $stable(err)));
endmodule

// File: tb/scaler_phase_calc_bench.sv
module scaler_phase_calc_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  plane_mask = '0;
  logic [31:0] src_w = '0, src_h = '0;
  logic [15:0] dst_w = '0, dst_h = '0;
  logic        rotated = 1'b0;
  logic [31:0] h_factor, v_factor, h_delta, v_delta;
  logic [19:0] h_init, v_init;
  logic [15:0] in_w, in_h, out_w, out_h;
  logic        enh_en, scale_en, err, done;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] hf, vf, hd, vd;
    logic [19:0] hi, vi;
    logic [15:0] iw, ih, ow, oh;
    logic        enh, sen, er;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  scaler_phase_calc u_scaler_phase_calc (
    .clk(clk), .rst_n(rst_n), .start(start), .plane_mask(plane_mask),
    .src_w(src_w), .src_h(src_h), .dst_w(dst_w), .dst_h(dst_h), .rotated(rotated),
    .h_factor(h_factor), .v_factor(v_factor), .h_init(h_init), .v_init(v_init),
    .h_delta(h_delta), .v_delta(v_delta), .in_w(in_w), .in_h(in_h),
    .out_w(out_w), .out_h(out_h), .enh_en(enh_en), .scale_en(scale_en),
    .err(err), .done(done)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk("R10", "unexpected done", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk("R3", {e.tag, " h_factor"}, h_factor, e.hf);
        chk("R3", {e.tag, " v_factor"}, v_factor, e.vf);
        chk("R6", {e.tag, " h_init"}, h_init, e.hi);
        chk("R6", {e.tag, " v_init"}, v_init, e.vi);
        chk("R7", {e.tag, " h_delta"}, h_delta, e.hd);
        chk("R7", {e.tag, " v_delta"}, v_delta, e.vd);
        chk("R5", {e.tag, " in_w"}, in_w, e.iw);
        chk("R5", {e.tag, " in_h"}, in_h, e.ih);
        chk("R8", {e.tag, " out_w"}, out_w, e.ow);
        chk("R8", {e.tag, " out_h"}, out_h, e.oh);
        chk("R4", {e.tag, " enh_en"}, enh_en, e.enh);
        chk(e.tag, "scale_en", scale_en, e.sen);
        chk(e.tag, "err", err, e.er);
      end
    end
  end

  task automatic issue(input logic [7:0] m, input logic [31:0] sw, input logic [31:0] sh,
                       input logic [15:0] dw, input logic [15:0] dh, input logic rot);
    exp_t e;
    logic [63:0] a, b, iw, ih;
    e.hf = '0; e.vf = '0; e.hd = '0; e.vd = '0; e.hi = '0; e.vi = '0;
    e.iw = '0; e.ih = '0; e.ow = '0; e.oh = '0; e.enh = 1'b0; e.sen = 1'b0; e.er = 1'b0;
    if (m == 8'd0) begin
      e.tag = "R1";
    end else if ((m & (m - 8'd1)) != 8'd0) begin
      e.tag = "R2"; e.er = 1'b1;
    end else if (sw == 0 || sh == 0 || dw == 0 || dh == 0) begin
      e.tag = "R9"; e.er = 1'b1;
    end else begin
      e.tag = "R8"; e.sen = 1'b1;
      a = ({48'd0, dw} << 32) / {32'd0, sw};
      b = ({48'd0, dh} << 32) / {32'd0, sh};
      e.hf = a[31:0]; e.vf = b[31:0];
      iw = rot ? {48'd0, sh[31:16]} : {48'd0, sw[31:16]};
      ih = rot ? {48'd0, sw[31:16]} : {48'd0, sh[31:16]};
      e.iw = iw[15:0]; e.ih = ih[15:0]; e.ow = dw; e.oh = dh;
      a = (((iw << 4) / {48'd0, dw}) + 64'd1) / 64'd2; e.hi = a[19:0];
      a = (((ih << 4) / {48'd0, dh}) + 64'd1) / 64'd2; e.vi = a[19:0];
      a = (iw << 16) / {48'd0, dw}; e.hd = a[31:0];
      a = (ih << 16) / {48'd0, dh}; e.vd = a[31:0];
      e.enh = (e.hf[31:16] >= 16'd2) || (e.vf[31:16] >= 16'd2);
    end
    sb.push_back(e);
    @(negedge clk);
    plane_mask = m; src_w = sw; src_h = sh; dst_w = dw; dst_h = dh; rotated = rot; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
    chk("R10", "done one cycle", done, 1'b0);
  endtask

  task automatic run(input logic [7:0] m, input logic [31:0] sw, input logic [31:0] sh,
                     input logic [15:0] dw, input logic [15:0] dh, input logic rot);
    logic [31:0] hf0, vd0;
    logic [19:0] hi0;
    logic e0, s0;
    issue(m, sw, sh, dw, dh, rot);
    wait_done();
    hf0 = h_factor; vd0 = v_delta; hi0 = h_init; e0 = err; s0 = scale_en;
    repeat (4) @(negedge clk);
    chk("R10", "hold h_factor", h_factor, hf0);
    chk("R10", "hold v_delta", v_delta, vd0);
    chk("R10", "hold h_init", h_init, hi0);
    chk("R10", "hold err/scale_en", {err, scale_en}, {e0, s0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "reset done", done, 1'b0);
    chk("R11", "reset err", err, 1'b0);
    chk("R11", "reset scale_en", scale_en, 1'b0);
    chk("R11", "reset enh_en", enh_en, 1'b0);
    chk("R11", "reset h_factor", h_factor, 32'd0);
    chk("R11", "reset v_delta", v_delta, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run(8'h00, 32'h0064_0000, 32'h0032_0000, 16'd200, 16'd50, 1'b0);
    run(8'h05, 32'h0064_0000, 32'h0032_0000, 16'd200, 16'd50, 1'b0);
    run(8'h02, 32'h0064_0000, 32'h0032_0000, 16'd200, 16'd50, 1'b0);
    run(8'h01, 32'h0780_0000, 32'h0438_0000, 16'd640, 16'd480, 1'b0);
    run(8'h10, 32'h012C_0000, 32'h0064_0000, 16'd100, 16'd300, 1'b1);
    run(8'h04, 32'h0002_0000, 32'h0002_0000, 16'd3, 16'd3, 1'b0);
    run(8'h04, 32'h0002_0000, 32'h0002_0000, 16'd3, 16'd4, 1'b0);
    run(8'h08, 32'h0001_8000, 32'h0007_4000, 16'd5, 16'd3, 1'b1);
    run(8'h80, 32'h0000_0001, 32'h0010_0000, 16'd65535, 16'd7, 1'b0);
    run(8'h02, 32'h0064_0000, 32'h0032_0000, 16'd200, 16'd0, 1'b0);
    run(8'h02, 32'h0000_0000, 32'h0032_0000, 16'd200, 16'd50, 1'b0);

    issue(8'h01, 32'h00F0_0000, 32'h00A0_0000, 16'd320, 16'd200, 1'b0);
    repeat (10) @(negedge clk);
    plane_mask = 8'h00; dst_w = 16'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    repeat (6) @(negedge clk);
    chk("R10", "scoreboard empty after ignored start", sb.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule